// File: doc/BRIEF.md
# Switching Regulator Fault Supervisor

This block is the digital fault handler for a voltage-mode buck regulator controller. It runs on the system clock. It sees a one-clock strobe at the start of every switching cycle and digitised comparator results: overcurrent, feedback undervoltage, over-temperature trip and temperature-recovered. It also sees the bias power-on-reset status, the level of the shared enable line and a pulse from the soft-start timer when a ramp completes. From these it decides when the power stage may run. It blanks the high-side switch for the rest of any cycle that saw overcurrent, and it counts unbroken runs of overcurrent cycles. It also decides whether an undervoltage is a fault in its own right or a result of overcurrent.

After an overcurrent or undervoltage shutdown, the supervisor holds the shared enable line low and retries in hiccup fashion. It restarts the soft-start timer itself and waits for four soft-start completions before it lets go of the line. Over-temperature stops the stage with hysteresis between the trip comparator and the recovery comparator. A two-bit status code names the last fault until a later soft-start completes cleanly.

The state machine has five states:
- OFF: idle.
- START: soft-start in progress, stage running.
- RUN: regulating.
- HICCUP: retry wait with the enable line pulled down.
- HOT: thermal lockout.

Transitions:
- OFF→START: power-on-reset valid, enable high, no thermal trip.
- START→RUN: soft-start done.
- START/RUN→OFF: enable or power-on-reset lost.
- START/RUN→HICCUP: overcurrent trip, or a qualified undervoltage.
- HICCUP→OFF: fourth soft-start completion.
- any of OFF, START, RUN or HICCUP→HOT: thermal trip.
- HOT→OFF: recovery compare high and trip compare low.

Top module: `buck_fault_sup`

## Requirements
- R1: `hs_blank` is high in the same clock that `oc_det` is high. It stays high until the next `cyc_strobe` clock. In a strobe clock it reflects only `oc_det` of that clock, because the strobe clock belongs to the new cycle.
- R2: At each strobe while running, a cycle that saw overcurrent raises an internal run counter by one and sets an overcurrent flag. A clean cycle resets the counter to zero. So seven overcurrent cycles, one clean cycle and seven more overcurrent cycles do not shut down.
- R3: Overcurrent is judged at the strobe. When the eighth consecutive overcurrent cycle is judged, the next clock edge drops `run`, raises `en_pulldown` and sets `fault_code` to 01.
- R4: If a clean cycle is judged while the run counter is below four, the overcurrent flag clears. A later undervoltage is then treated as R6.
- R5: An undervoltage while the flag is set and the counter is below four shuts down at the next edge with `fault_code` 01 and `en_pulldown` high. An undervoltage while the flag is set and the counter is at four or more is ignored. A clean cycle at a count of four or more clears the counter but leaves the flag set.
- R6: An undervoltage while the flag is clear shuts down at the next edge with `fault_code` 10 and `en_pulldown` high.
- R7: In hiccup, `en_pulldown` stays high and `en_in` is ignored. `ss_restart` pulses for one clock on entry and after each of the first three `ss_done` pulses. The fourth `ss_done` releases `en_pulldown` and goes to OFF, with the counters reset.
- R8: `ot_hot` high drops `run` at the next edge and sets `fault_code` to 11. The block stays stopped until `ot_cool` is high and `ot_hot` is low.
- R9: A start needs `por_ok` and `en_in` high and `ot_hot` low. `run` rises at the edge after these hold, and `ss_restart` is high for exactly that first clock.
- R10: `fault_code` uses 00 none, 01 overcurrent, 10 undervoltage and 11 thermal. It keeps the last cause until an `ss_done` completes a soft-start, which clears it to 00.
- R11: Loss of `en_in` or `por_ok` while in START or RUN drops `run` at the next edge without `en_pulldown`.
- R12: After reset, `run`, `en_pulldown`, `ss_restart` and `fault_code` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cyc_strobe | input | 1 | One-clock pulse at the start of each switching cycle |
| oc_det | input | 1 | Overcurrent detected (either switch) |
| uv_det | input | 1 | Feedback below undervoltage level |
| ot_hot | input | 1 | Junction at or above trip temperature |
| ot_cool | input | 1 | Junction below recovery temperature |
| por_ok | input | 1 | Bias power-on-reset valid |
| en_in | input | 1 | Enable line above rising threshold |
| ss_done | input | 1 | One-clock pulse when a soft-start ramp completes |
| run | output | 1 | Power stage may switch |
| hs_blank | output | 1 | Hold high-side switch off for the rest of this cycle |
| en_pulldown | output | 1 | Pull the shared enable line low |
| ss_restart | output | 1 | One-clock pulse to restart the soft-start timer |
| fault_code | output | 2 | Last fault cause (00/01/10/11) |

## Verification
A wrong run counter shows up as a shutdown one strobe too early or too late, seen as `en_pulldown` rising. A counter that fails to reset shows up as a shutdown after a broken run of overcurrent cycles. A wrong overcurrent flag shows up within one clock of an undervoltage, either as the wrong `fault_code` (01 against 10) or as a shutdown where none is due. A slipped hiccup count moves the fall of `en_pulldown` by a whole `ss_done` pulse and adds or drops an `ss_restart` pulse. A broken thermal latch lets `run` rise while `ot_cool` is still low.

// File: rtl/fsup_pkg.sv
package fsup_pkg;

    typedef enum logic [2:0] {
        ST_OFF    = 3'd0,
        ST_START  = 3'd1,
        ST_RUN    = 3'd2,
        ST_HICCUP = 3'd3,
        ST_HOT    = 3'd4
    } fsup_state_e;

    typedef enum logic [1:0] {
        FC_NONE  = 2'b00,
        FC_OC    = 2'b01,
        FC_UV    = 2'b10,
        FC_THERM = 2'b11
    } fsup_code_e;

endpackage

// File: rtl/fsup_oc_track.sv
module fsup_oc_track #(
    parameter int SHUT_CNT = 8,
    parameter int FLAG_LIM = 4
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          active,
    input  logic                          strobe,
    input  logic                          oc_det,
    output logic [$clog2(SHUT_CNT+1)-1:0] cnt,
    output logic                          flag,
    output logic                          trip,
    output logic                          blank
);
    localparam int CW = $clog2(SHUT_CNT + 1);
    localparam logic [CW-1:0] CNT_LAST = CW'(SHUT_CNT - 1);
    localparam logic [CW-1:0] CNT_MAX  = CW'(SHUT_CNT);
    localparam logic [CW-1:0] CNT_FLAG = CW'(FLAG_LIM);

    // overcurrent seen so far in the current switching cycle
    logic pend;

    always_ff @(posedge clk) begin
        if (!rst_n || !active) begin
            pend <= 1'b0;
            cnt  <= '0;
            flag <= 1'b0;
        end else begin
            pend <= strobe ? oc_det : (pend | oc_det);
            if (strobe) begin
                if (pend) begin
                    if (cnt != CNT_MAX) begin
                        cnt <= cnt + 1'b1;
                    end
                    flag <= 1'b1;
                end else begin
                    cnt <= '0;
                    if (cnt < CNT_FLAG) begin
                        flag <= 1'b0;
                    end
                end
            end
        end
    end

    always_comb begin
        trip  = active & strobe & pend & (cnt == CNT_LAST);
        blank = oc_det | (pend & ~strobe);
    end

endmodule

// File: rtl/fsup_hiccup.sv
module fsup_hiccup #(
    parameter int PERIODS = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic wait_en,
    input  logic ss_done,
    output logic done
);
    localparam int HW = $clog2(PERIODS + 1);
    localparam logic [HW-1:0] HLAST = HW'(PERIODS - 1);

    logic [HW-1:0] seen;

    always_ff @(posedge clk) begin
        if (!rst_n || !wait_en) begin
            seen <= '0;
        end else if (ss_done) begin
            seen <= seen + 1'b1;
        end
    end

    always_comb begin
        done = wait_en & ss_done & (seen == HLAST);
    end

endmodule

// File: rtl/buck_fault_sup.sv
module buck_fault_sup
    import fsup_pkg::*;
#(
    parameter int OC_SHUT_CNT    = 8,
    parameter int OC_FLAG_LIM    = 4,
    parameter int HICCUP_PERIODS = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cyc_strobe,
    input  logic       oc_det,
    input  logic       uv_det,
    input  logic       ot_hot,
    input  logic       ot_cool,
    input  logic       por_ok,
    input  logic       en_in,
    input  logic       ss_done,
    output logic       run,
    output logic       hs_blank,
    output logic       en_pulldown,
    output logic       ss_restart,
    output logic [1:0] fault_code
);
    localparam int CW = $clog2(OC_SHUT_CNT + 1);
    localparam logic [CW-1:0] FLAG_LIM_C = CW'(OC_FLAG_LIM);

    fsup_state_e   st, st_nxt;
    fsup_code_e    code_q, code_nxt;
    logic          active, in_hiccup;
    logic [CW-1:0] oc_cnt;
    logic          oc_flag, oc_trip, hic_done;
    logic          uv_alone, uv_after_oc;
    logic          restart_nxt;

    always_comb begin
        active    = (st == ST_START) || (st == ST_RUN);
        in_hiccup = (st == ST_HICCUP);
    end

    fsup_oc_track #(
        .SHUT_CNT (OC_SHUT_CNT),
        .FLAG_LIM (OC_FLAG_LIM)
    ) u_oc (
        .clk    (clk),
        .rst_n  (rst_n),
        .active (active),
        .strobe (cyc_strobe),
        .oc_det (oc_det),
        .cnt    (oc_cnt),
        .flag   (oc_flag),
        .trip   (oc_trip),
        .blank  (hs_blank)
    );

    fsup_hiccup #(
        .PERIODS (HICCUP_PERIODS)
    ) u_hic (
        .clk     (clk),
        .rst_n   (rst_n),
        .wait_en (in_hiccup),
        .ss_done (ss_done),
        .done    (hic_done)
    );

    always_comb begin
        uv_alone    = uv_det & ~oc_flag;
        uv_after_oc = uv_det & oc_flag & (oc_cnt < FLAG_LIM_C);
    end

    // next state and next status code
    always_comb begin
        st_nxt   = st;
        code_nxt = code_q;
        unique case (st)
            ST_OFF: begin
                if (ot_hot) begin
                    st_nxt   = ST_HOT;
                    code_nxt = FC_THERM;
                end else if (por_ok && en_in) begin
                    st_nxt = ST_START;
                end
            end
            ST_START, ST_RUN: begin
                if (ot_hot) begin
                    st_nxt   = ST_HOT;
                    code_nxt = FC_THERM;
                end else if (!por_ok || !en_in) begin
                    st_nxt = ST_OFF;
                end else if (oc_trip || uv_after_oc) begin
                    st_nxt   = ST_HICCUP;
                    code_nxt = FC_OC;
                end else if (uv_alone) begin
                    st_nxt   = ST_HICCUP;
                    code_nxt = FC_UV;
                end else if (st == ST_START && ss_done) begin
                    st_nxt   = ST_RUN;
                    code_nxt = FC_NONE;
                end
            end
            ST_HICCUP: begin
                if (ot_hot) begin
                    st_nxt   = ST_HOT;
                    code_nxt = FC_THERM;
                end else if (hic_done) begin
                    st_nxt = ST_OFF;
                end
            end
            ST_HOT: begin
                if (ot_cool && !ot_hot) begin
                    st_nxt = ST_OFF;
                end
            end
            default: begin
                st_nxt = ST_OFF;
            end
        endcase
    end

    always_comb begin
        restart_nxt = ((st_nxt == ST_START) && (st != ST_START))
                    || ((st_nxt == ST_HICCUP) && (st != ST_HICCUP))
                    || ((st == ST_HICCUP) && (st_nxt == ST_HICCUP) && ss_done);
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st <= ST_OFF;
        end else begin
            st <= st_nxt;
        end
    end

    // registered outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            code_q      <= FC_NONE;
            run         <= 1'b0;
            en_pulldown <= 1'b0;
            ss_restart  <= 1'b0;
        end else begin
            code_q      <= code_nxt;
            run         <= (st_nxt == ST_START) || (st_nxt == ST_RUN);
            en_pulldown <= (st_nxt == ST_HICCUP);
            ss_restart  <= restart_nxt;
        end
    end

    always_comb begin
        fault_code = code_q;
    end

endmodule

// File: rtl/fsup_checker.sv
module fsup_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       cyc_strobe,
    input logic       oc_det,
    input logic       ot_hot,
    input logic       por_ok,
    input logic       en_in,
    input logic       ss_done,
    input logic       run,
    input logic       hs_blank,
    input logic       en_pulldown,
    input logic       ss_restart,
    input logic [1:0] fault_code
);
    a_r1_blank_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (run && $past(run) && $past(oc_det) && !cyc_strobe) |-> hs_blank);

    a_r3_shut_from_run: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(en_pulldown) |-> $past(run));

    a_r7_restart_on_entry: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(en_pulldown) |-> ss_restart);

    a_r7_release_to_off: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(en_pulldown) |-> !run);

    a_r7_no_run_in_pulldown: assert property (@(posedge clk) disable iff (!rst_n)
        !(run && en_pulldown));

    a_r8_hot_stops: assert property (@(posedge clk) disable iff (!rst_n)
        ot_hot |=> !run);

    a_r9_start_qualified: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(run) |-> ($past(por_ok) && $past(en_in) && !$past(ot_hot) && ss_restart));

    a_r10_clear_on_done: assert property (@(posedge clk) disable iff (!rst_n)
        ((fault_code == 2'b00) && ($past(fault_code) != 2'b00)) |-> ($past(ss_done) && run));

endmodule

bind buck_fault_sup fsup_checker u_fsup_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cyc_strobe  (cyc_strobe),
    .oc_det      (oc_det),
    .ot_hot      (ot_hot),
    .por_ok      (por_ok),
    .en_in       (en_in),
    .ss_done     (ss_done),
    .run         (run),
    .hs_blank    (hs_blank),
    .en_pulldown (en_pulldown),
    .ss_restart  (ss_restart),
    .fault_code  (fault_code)
);

// File: tb/tb_buck_fault_sup.sv
module tb_buck_fault_sup;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cyc_strobe = 1'b0, oc_det = 1'b0, uv_det = 1'b0;
    logic       ot_hot = 1'b0, ot_cool = 1'b0, por_ok = 1'b0;
    logic       en_in = 1'b0, ss_done = 1'b0;
    logic       run, hs_blank, en_pulldown, ss_restart;
    logic [1:0] fault_code;

    int n_chk = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    buck_fault_sup dut (
        .clk(clk), .rst_n(rst_n), .cyc_strobe(cyc_strobe), .oc_det(oc_det),
        .uv_det(uv_det), .ot_hot(ot_hot), .ot_cool(ot_cool), .por_ok(por_ok),
        .en_in(en_in), .ss_done(ss_done), .run(run), .hs_blank(hs_blank),
        .en_pulldown(en_pulldown), .ss_restart(ss_restart), .fault_code(fault_code)
    );

    // {strobe, oc, uv, en, ss_done} -> {run, pulldown, code[1:0]} after the edge
    localparam int NV = 52;
    localparam logic [8:0] VEC [NV] = '{
        9'b00000_0000, 9'b00010_1000, 9'b00011_1000, 9'b00110_0110,
        9'b00001_0110, 9'b00001_0110, 9'b00001_0110, 9'b00001_0010,
        9'b00010_1010, 9'b00011_1000, 9'b01010_1000,
        9'b11010_1000, 9'b11010_1000, 9'b11010_1000, 9'b11010_1000,
        9'b11010_1000, 9'b11010_1000, 9'b11010_1000, 9'b11010_0101,
        9'b00011_0101, 9'b00011_0101, 9'b00011_0101, 9'b00011_0001,
        9'b00010_1001, 9'b00011_1000,
        9'b11010_1000, 9'b10010_1000, 9'b00110_0101,
        9'b00001_0101, 9'b00001_0101, 9'b00001_0101, 9'b00001_0001,
        9'b00010_1001, 9'b00011_1000,
        9'b11010_1000, 9'b11010_1000, 9'b11010_1000, 9'b11010_1000,
        9'b10010_1000, 9'b00110_1000, 9'b10010_1000, 9'b00110_0101,
        9'b00001_0101, 9'b00001_0101, 9'b00001_0101, 9'b00001_0001,
        9'b00010_1001, 9'b00011_1000,
        9'b11010_1000, 9'b10010_1000, 9'b10010_1000, 9'b00110_0110
    };

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic step(input logic s, input logic o, input logic u,
                        input logic e, input logic d);
        cyc_strobe = s; oc_det = o; uv_det = u; en_in = e; ss_done = d;
        @(negedge clk);
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R12 reset state
        chk("R12 run", int'(run), 0);
        chk("R12 pulldown", int'(en_pulldown), 0);
        chk("R12 restart", int'(ss_restart), 0);
        chk("R12 code", int'(fault_code), 0);
        por_ok = 1'b1;
        ot_cool = 1'b1;

        // table: R2 R3 R4 R5 R6 R7 R10
        for (int i = 0; i < NV; i++) begin
            step(VEC[i][8], VEC[i][7], VEC[i][6], VEC[i][5], VEC[i][4]);
            chk($sformatf("R3 R5 R6 vec%0d run", i), int'(run), int'(VEC[i][3]));
            chk($sformatf("R7 vec%0d pulldown", i), int'(en_pulldown), int'(VEC[i][2]));
            chk($sformatf("R10 vec%0d code", i), int'(fault_code), int'(VEC[i][1:0]));
        end

        // leave hiccup and return to RUN
        repeat (4) step(0, 0, 0, 1, 1);
        step(0, 0, 0, 1, 0);
        step(0, 0, 0, 1, 1);
        chk("R10 code cleared", int'(fault_code), 0);

        // R7 restart pulses and release
        step(0, 0, 1, 1, 0);
        chk("R7 entry pulldown", int'(en_pulldown), 1);
        chk("R7 entry restart", int'(ss_restart), 1);
        step(0, 0, 0, 0, 0);
        chk("R7 restart one clock", int'(ss_restart), 0);
        chk("R7 en ignored", int'(en_pulldown), 1);
        step(0, 0, 0, 0, 1);
        chk("R7 restart after done", int'(ss_restart), 1);
        step(0, 0, 0, 0, 1);
        step(0, 0, 0, 0, 1);
        chk("R7 still held", int'(en_pulldown), 1);
        step(0, 0, 0, 0, 1);
        chk("R7 released", int'(en_pulldown), 0);
        chk("R7 no restart on release", int'(ss_restart), 0);
        chk("R7 off after release", int'(run), 0);

        // R9 / R11 start qualification
        por_ok = 1'b0;
        step(0, 0, 0, 1, 0);
        chk("R9 no start without por", int'(run), 0);
        por_ok = 1'b1;
        step(0, 0, 0, 1, 0);
        chk("R9 start", int'(run), 1);
        chk("R9 start restart pulse", int'(ss_restart), 1);
        step(0, 0, 0, 1, 0);
        chk("R9 pulse one clock", int'(ss_restart), 0);
        step(0, 0, 0, 1, 1);
        step(0, 0, 0, 0, 0);
        chk("R11 enable loss", int'(run), 0);
        chk("R11 no pulldown", int'(en_pulldown), 0);
        step(0, 0, 0, 1, 0);
        step(0, 0, 0, 1, 1);
        chk("R9 running again", int'(run), 1);

        // R1 high-side blanking
        cyc_strobe = 0; oc_det = 1; #1;
        chk("R1 blank same clock", int'(hs_blank), 1);
        @(negedge clk);
        oc_det = 0; #1;
        chk("R1 blank held in cycle", int'(hs_blank), 1);
        @(negedge clk);
        cyc_strobe = 1; #1;
        chk("R1 blank ends at strobe", int'(hs_blank), 0);
        @(negedge clk);
        step(1, 0, 0, 1, 0);

        // R2 broken runs do not shut down
        for (int k = 0; k < 7; k++) step(1, 1, 0, 1, 0);
        step(1, 0, 0, 1, 0);
        step(1, 0, 0, 1, 0);
        for (int k = 0; k < 7; k++) step(1, 1, 0, 1, 0);
        step(1, 0, 0, 1, 0);
        step(1, 0, 0, 1, 0);
        chk("R2 no shutdown run", int'(run), 1);
        chk("R2 no shutdown pulldown", int'(en_pulldown), 0);

        // R8 thermal hysteresis
        ot_hot = 1'b1;
        step(0, 0, 0, 1, 0);
        chk("R8 hot stops", int'(run), 0);
        chk("R8 hot code", int'(fault_code), 3);
        ot_hot = 1'b0;
        ot_cool = 1'b0;
        repeat (3) step(0, 0, 0, 1, 0);
        chk("R8 held until cool", int'(run), 0);
        ot_cool = 1'b1;
        step(0, 0, 0, 1, 0);
        chk("R8 cool to off", int'(run), 0);
        step(0, 0, 0, 1, 0);
        chk("R8 restart after cool", int'(run), 1);
        chk("R10 code kept in start", int'(fault_code), 3);
        step(0, 0, 0, 1, 1);
        chk("R10 code cleared after start", int'(fault_code), 0);

        finish_run();
    end

endmodule